// File: doc/BRIEF.md
# Multi-Mode Timer/Event Counter

A 16-bit counter that one byte-wide control register switches between seven behaviours: an interval timer that clears on a compare match, an event counter, PWM that a trigger starts, a single pulse that a trigger launches, free-running PWM, a free-running counter, and pulse-width capture. The same register chooses what advances the counter. That is either a count-clock enable supplied from outside or rising edges on an external event pin. The register also carries a trigger bit that software writes and that never holds a value.

The timer runs while `run_en` is high. Two compare values come in as ports. The external event, trigger and capture pins are asynchronous. Each one passes through a two-flop synchroniser and a rising-edge detector before the counter logic uses it. Mode and source may change only while the timer is stopped. A write that tries to change them while the timer runs is discarded, and the existing setting stays in force.

Top module: `multi_mode_timer`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, which means interval mode with the internal source. `count`, `capture`, `match_flag` and `tmr_out` are all 0.
- R2: Bits 2:0 of the control byte hold the mode: 000 interval, 001 event count, 010 triggered PWM, 011 one-shot, 100 PWM, 101 free-running, 110 pulse width, 111 unsupported. Bit 5 selects the source, where 1 means external event edges. Both fields read back. Bits 7, 6, 4 and 3 always read 0.
- R3: While `run_en` is 1, a write that changes bits 2:0 or bit 5 leaves the register unchanged. A write with identical mode and source is accepted. While `run_en` is 0, every write is accepted.
- R4: In interval mode, the counter advances on each cycle in which the step source is active. On a step taken while `count` equals `cmp0`, the counter goes to 0 instead, and `match_flag` is high for that one following cycle. `tmr_out` stays low.
- R5: When bit 5 is 1, or in event-count mode whatever bit 5 holds, each rising edge of `evt_in` adds exactly one to the counter and `cnt_tick` is ignored. Otherwise the counter steps on `cnt_tick`.
- R6: A write with bit 6 set has no effect on the counter except in triggered-PWM and one-shot modes. `trig_in` edges are likewise ignored in the other modes.
- R7: In one-shot mode, a trigger (a bit-6 write or a `trig_in` rising edge) raises `tmr_out` for cmp0+1 steps. The output then falls and `count` returns to 0. A trigger while the pulse is active is ignored.
- R8: In triggered-PWM mode, `tmr_out` and `count` stay 0 until a trigger. After the trigger, the counter wraps from `cmp0` to 0 and `tmr_out` equals (`count` < `cmp1`). A new trigger restarts the count at 0.
- R9: In PWM mode, the counter steps through 0..`cmp0` and then wraps. `tmr_out` equals (`count` < `cmp1`) after the first running cycle.
- R10: In free-running mode, the counter increments on every step and never clears on a match. `match_flag` pulses for one cycle after a step taken from a count equal to `cmp0`.
- R11: In pulse-width mode, a synchronised `cap_in` rising edge copies `count` into `capture` and clears the counter. If a step falls in the same cycle, the capture wins: the value taken is the count before that step, and the counter reads 0 afterwards.
- R12: One cycle after `run_en` is 0, `count` is 0 and `tmr_out` is low. In mode 111, the counter stays at 0 and the output stays low even while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| run_en | input | 1 | Timer run enable |
| cnt_tick | input | 1 | Internal count-clock enable |
| evt_in | input | 1 | Asynchronous external event input |
| trig_in | input | 1 | Asynchronous external trigger input |
| cap_in | input | 1 | Asynchronous capture input |
| cmp0 | input | 16 | Compare 0: period or match value |
| cmp1 | input | 16 | Compare 1: duty threshold |
| count | output | 16 | Current counter value |
| capture | output | 16 | Last captured width |
| match_flag | output | 1 | One-cycle compare-match pulse |
| tmr_out | output | 1 | Timer output pin |

## Verification
In pulse-width mode, a capture edge and a count step can land on the same clock edge. The bench holds `cnt_tick` high so that every capture coincides with a step. It then spaces `cap_in` rising edges by random widths and samples the outputs one cycle after each capture. The capture register must hold the width minus one, which is the count before the step, and `count` must read 0, not 1. A checker property independently ties each internal capture event to the count of the previous cycle.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [2:0] {
    M_INTERVAL = 3'd0,
    M_EVENT    = 3'd1,
    M_TRIGPWM  = 3'd2,
    M_ONESHOT  = 3'd3,
    M_PWM      = 3'd4,
    M_FREE     = 3'd5,
    M_PWIDTH   = 3'd6,
    M_BAD      = 3'd7
  } mode_e;

  // Mode and source unchanged between stored byte fields and a new write.
  function automatic logic cfg_same(mode_e cur_mode, logic cur_src, logic [7:0] wr);
    return (cur_mode == mode_e'(wr[2:0])) && (cur_src == wr[5]);
  endfunction

  function automatic logic trig_mode(mode_e m);
    return (m == M_TRIGPWM) || (m == M_ONESHOT);
  endfunction

  function automatic logic ext_source(mode_e m, logic src);
    return src || (m == M_EVENT);
  endfunction

endpackage

// File: rtl/mmt_ctrl_reg.sv
module mmt_ctrl_reg
  import mmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       run_en,
  output mode_e      mode,
  output logic       src,
  output logic       sw_trig,
  output logic [7:0] rdata
);

  logic accept;

  assign accept = we && (!run_en || cfg_same(mode, src, wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_INTERVAL;
      src  <= 1'b0;
    end else if (accept) begin
      mode <= mode_e'(wdata[2:0]);
      src  <= wdata[5];
    end
  end

  assign sw_trig = we && wdata[6] && trig_mode(mode);
  assign rdata   = {2'b00, src, 2'b00, mode};

endmodule

// File: rtl/mmt_edge_sync.sv
module mmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/mmt_core.sv
module mmt_core
  import mmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  mode_e        mode,
  input  logic         step,
  input  logic         trig,
  input  logic         cap,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  output logic [W-1:0] count,
  output logic [W-1:0] capture,
  output logic         match,
  output logic         out
);

  function automatic logic [W-1:0] wrap_next(logic [W-1:0] c, logic [W-1:0] top);
    return (c == top) ? '0 : c + 1'b1;
  endfunction

  function automatic logic pwm_level(logic [W-1:0] c, logic [W-1:0] duty);
    return c < duty;
  endfunction

  logic         armed, armed_n, match_n, out_n;
  logic [W-1:0] cnt_n, cap_n;

  always_comb begin
    cnt_n   = count;
    armed_n = armed;
    cap_n   = capture;
    match_n = 1'b0;
    out_n   = 1'b0;
    if (!run_en) begin
      cnt_n   = '0;
      armed_n = 1'b0;
    end else begin
      unique case (mode)
        M_INTERVAL, M_EVENT: begin
          if (step) begin
            cnt_n   = wrap_next(count, cmp0);
            match_n = (count == cmp0);
          end
        end
        M_FREE: begin
          if (step) begin
            cnt_n   = count + 1'b1;
            match_n = (count == cmp0);
          end
        end
        M_PWM: begin
          if (step) cnt_n = wrap_next(count, cmp0);
          out_n = pwm_level(cnt_n, cmp1);
        end
        M_TRIGPWM: begin
          if (trig) begin
            armed_n = 1'b1;
            cnt_n   = '0;
          end else if (armed && step) begin
            cnt_n = wrap_next(count, cmp0);
          end
          out_n = armed_n && pwm_level(cnt_n, cmp1);
        end
        M_ONESHOT: begin
          if (trig && !armed) begin
            armed_n = 1'b1;
            cnt_n   = '0;
          end else if (armed && step) begin
            if (count == cmp0) begin
              armed_n = 1'b0;
              cnt_n   = '0;
            end else begin
              cnt_n = count + 1'b1;
            end
          end
          out_n = armed_n;
        end
        M_PWIDTH: begin
          if (cap) begin
            cap_n = count;
            cnt_n = '0;
          end else if (step) begin
            cnt_n = count + 1'b1;
          end
        end
        default: begin
          cnt_n   = '0;
          armed_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      capture <= '0;
      armed   <= 1'b0;
      match   <= 1'b0;
      out     <= 1'b0;
    end else begin
      count   <= cnt_n;
      capture <= cap_n;
      armed   <= armed_n;
      match   <= match_n;
      out     <= out_n;
    end
  end

endmodule

// File: rtl/multi_mode_timer.sv
module multi_mode_timer
  import mmt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             run_en,
  input  logic             cnt_tick,
  input  logic             evt_in,
  input  logic             trig_in,
  input  logic             cap_in,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capture,
  output logic             match_flag,
  output logic             tmr_out
);

  localparam int N_ASYNC = 3;

  mode_e              mode;
  logic               src, sw_trig;
  logic [N_ASYNC-1:0] raw_in, rise;
  logic               evt_rise, trig_rise, cap_rise;
  logic               step, trig_go, cap_hit;

  mmt_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .wdata   (reg_wdata),
    .run_en  (run_en),
    .mode    (mode),
    .src     (src),
    .sw_trig (sw_trig),
    .rdata   (reg_rdata)
  );

  assign raw_in = {cap_in, trig_in, evt_in};

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    mmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_in[g]),
      .rise  (rise[g])
    );
  end

  assign evt_rise  = rise[0];
  assign trig_rise = rise[1];
  assign cap_rise  = rise[2];

  assign step    = ext_source(mode, src) ? evt_rise : cnt_tick;
  assign trig_go = sw_trig || (trig_rise && trig_mode(mode));
  assign cap_hit = run_en && (mode == M_PWIDTH) && cap_rise;

  mmt_core #(.W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .mode    (mode),
    .step    (step),
    .trig    (trig_go),
    .cap     (cap_hit),
    .cmp0    (cmp0),
    .cmp1    (cmp1),
    .count   (count),
    .capture (capture),
    .match   (match_flag),
    .out     (tmr_out)
  );

endmodule

// File: rtl/multi_mode_timer_chk.sv
module multi_mode_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic [7:0]       reg_rdata,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capture,
  input logic [CNT_W-1:0] cmp1,
  input logic             match_flag,
  input logic             tmr_out,
  input logic             cap_hit
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7:6] == 2'b00) && (reg_rdata[4:3] == 2'b00));

  // R3
  run_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_en) |-> $stable(reg_rdata));

  // R12
  halt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (count == '0) && !tmr_out);

  // R4
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag && (reg_rdata[2:1] == 2'b00) |-> (count == '0));

  // R11
  capture_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (capture == $past(count)) && (count == '0));

  // R9
  pwm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_en) && (reg_rdata[2:0] == 3'd4) && $stable(cmp1) |-> (tmr_out == (count < cmp1)));

endmodule

bind multi_mode_timer multi_mode_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .reg_rdata  (reg_rdata),
  .count      (count),
  .capture    (capture),
  .cmp1       (cmp1),
  .match_flag (match_flag),
  .tmr_out    (tmr_out),
  .cap_hit    (cap_hit)
);

// File: tb/test_multi_mode_timer.sv
module test_multi_mode_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        run_en = 1'b0, cnt_tick = 1'b0;
  logic        evt_in = 1'b0, trig_in = 1'b0, cap_in = 1'b0;
  logic [15:0] cmp0 = '0, cmp1 = '0;
  logic [15:0] count, capture;
  logic        match_flag, tmr_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  multi_mode_timer i_multi_mode_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .run_en(run_en), .cnt_tick(cnt_tick),
    .evt_in(evt_in), .trig_in(trig_in), .cap_in(cap_in), .cmp0(cmp0),
    .cmp1(cmp1), .count(count), .capture(capture), .match_flag(match_flag),
    .tmr_out(tmr_out)
  );

  function automatic logic [15:0] exp_interval(logic [15:0] c, logic [15:0] p);
    if (c == p) return 16'd0;
    return c + 16'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic stop_cfg(input logic [7:0] v);
    run_en = 1'b0;
    @(negedge clk);
    wr(v);
  endtask

  task automatic evt_pulse();
    evt_in = 1'b1; repeat (2) @(negedge clk);
    evt_in = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] e, c0;
    int highs;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(reg_rdata == 8'h00, "R1", "rdata", reg_rdata, 0);
    chk(count == 0 && capture == 0, "R1", "count/capture", count, 0);
    chk(!match_flag && !tmr_out, "R1", "flag/out", {match_flag, tmr_out}, 0);

    // R2 field readback, reserved bits read 0
    wr(8'hFF);
    chk(reg_rdata == 8'h27, "R2", "all-ones readback", reg_rdata, 8'h27);
    // R12 mode 111 stays stopped while running
    cnt_tick = 1'b1; run_en = 1'b1;
    repeat (6) @(negedge clk);
    chk(count == 0 && !tmr_out, "R12", "mode 111 idle", count, 0);

    // R3 run lock
    stop_cfg(8'h04);
    run_en = 1'b1;
    wr(8'h00);
    chk(reg_rdata == 8'h04, "R3", "mode change while running", reg_rdata, 8'h04);
    wr(8'h24);
    chk(reg_rdata == 8'h04, "R3", "source change while running", reg_rdata, 8'h04);
    wr(8'h04);
    chk(reg_rdata == 8'h04, "R3", "same value while running", reg_rdata, 8'h04);
    stop_cfg(8'h24);
    chk(reg_rdata == 8'h24, "R3", "write while stopped", reg_rdata, 8'h24);

    // R4 interval with random count-clock enables
    stop_cfg(8'h00);
    cmp0 = 16'd5; cnt_tick = 1'b0; run_en = 1'b1;
    @(negedge clk);
    e = 0;
    for (int i = 0; i < 60; i++) begin
      logic [15:0] prev;
      cnt_tick = ($urandom_range(0, 3) != 0);
      prev = e;
      @(negedge clk);
      if (cnt_tick) e = exp_interval(prev, cmp0);
      chk(count == e, "R4", "interval count", count, e);
      chk(match_flag == (cnt_tick && prev == cmp0), "R4", "match flag", match_flag,
          cnt_tick && prev == cmp0);
      chk(!tmr_out, "R4", "output low", tmr_out, 0);
    end

    // R5 external source via bit 5, then event mode with bit 5 clear
    stop_cfg(8'h20);
    cmp0 = 16'd1000; cnt_tick = 1'b1; run_en = 1'b1;
    repeat (6) evt_pulse();
    repeat (3) @(negedge clk);
    chk(count == 6, "R5", "bit5 event edges", count, 6);
    stop_cfg(8'h01);
    run_en = 1'b1;
    repeat (4) evt_pulse();
    repeat (3) @(negedge clk);
    chk(count == 4, "R5", "event mode edges", count, 4);

    // R6 trigger ignored in free-running mode
    stop_cfg(8'h05);
    cmp0 = 16'd1000; cnt_tick = 1'b1; run_en = 1'b1;
    repeat (7) @(negedge clk);
    cnt_tick = 1'b0;
    @(negedge clk);
    c0 = count;
    wr(8'h45);
    @(negedge clk);
    chk(count == c0, "R6", "sw trigger in free mode", count, c0);
    chk(reg_rdata == 8'h05, "R6", "trigger bit reads 0", reg_rdata, 8'h05);
    trig_in = 1'b1; repeat (2) @(negedge clk); trig_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(count == c0, "R6", "trig_in in free mode", count, c0);

    // R10 free-running: passes cmp0 without clearing
    stop_cfg(8'h05);
    cmp0 = 16'd3; run_en = 1'b1;
    @(negedge clk);
    e = 0;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] prev;
      cnt_tick = ($urandom_range(0, 3) != 0);
      prev = e;
      @(negedge clk);
      if (cnt_tick) e = prev + 16'd1;
      chk(count == e, "R10", "free count", count, e);
      chk(match_flag == (cnt_tick && prev == cmp0), "R10", "free match", match_flag,
          cnt_tick && prev == cmp0);
    end

    // R12 stop clears
    run_en = 1'b0;
    @(negedge clk);
    chk(count == 0 && !tmr_out, "R12", "stop clears", count, 0);

    // R7 one-shot by software and by pin, retrigger ignored
    wr(8'h03);
    cmp0 = 16'd9; cnt_tick = 1'b1; run_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(!tmr_out && count == 0, "R7", "idle before trigger", tmr_out, 0);
    wr(8'h43);
    highs = tmr_out;
    for (int i = 0; i < 20; i++) begin
      if (i == 3) trig_in = 1'b1;
      if (i == 5) trig_in = 1'b0;
      @(negedge clk);
      highs += tmr_out;
    end
    chk(highs == 10, "R7", "sw pulse length", highs, 10);
    chk(!tmr_out && count == 0, "R7", "after pulse", count, 0);
    highs = 0;
    trig_in = 1'b1;
    for (int i = 0; i < 30; i++) begin
      if (i == 2) trig_in = 1'b0;
      @(negedge clk);
      highs += tmr_out;
    end
    chk(highs == 10, "R7", "pin pulse length", highs, 10);

    // R8 triggered PWM
    stop_cfg(8'h02);
    cmp0 = 16'd7; cmp1 = 16'd3; run_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(!tmr_out && count == 0, "R8", "idle before trigger", tmr_out, 0);
    trig_in = 1'b1; repeat (2) @(negedge clk); trig_in = 1'b0;
    repeat (4) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      highs += tmr_out;
      chk(tmr_out == (count < cmp1) && count <= cmp0, "R8", "level vs count", tmr_out, count < cmp1);
    end
    chk(highs == 15, "R8", "high cycles in 5 periods", highs, 15);
    repeat (2) @(negedge clk);
    wr(8'h42);
    chk(count == 0, "R8", "retrigger restarts", count, 0);

    // R9 PWM with random enables
    stop_cfg(8'h04);
    cmp0 = 16'd9; cmp1 = 16'd4; cnt_tick = 1'b0; run_en = 1'b1;
    @(negedge clk);
    e = 0;
    for (int i = 0; i < 60; i++) begin
      cnt_tick = ($urandom_range(0, 1) != 0);
      @(negedge clk);
      if (cnt_tick) e = exp_interval(e, cmp0);
      chk(count == e, "R9", "pwm count", count, e);
      chk(tmr_out == (e < cmp1), "R9", "pwm level", tmr_out, e < cmp1);
    end

    // R11 pulse width; step and capture coincide every time
    stop_cfg(8'h06);
    cnt_tick = 1'b1; run_en = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      int w;
      w = $urandom_range(6, 40);
      cap_in = 1'b1;
      repeat (3) @(negedge clk);
      chk(count == 0, "R11", "cleared after capture", count, 0);
      if (k > 0) chk(capture == 16'(e - 1), "R11", "captured width", capture, e - 1);
      cap_in = 1'b0;
      repeat (w - 3) @(negedge clk);
      e = 16'(w);
    end

    done = 1'b1;
    finish_run();
  end

endmodule